// File: doc/BRIEF.md
# Limit-Checking ADC Command Sequencer

This block is the digital control core of a three-channel, 10-bit data acquisition monitor. A serial bus front end, which is not part of this block, hands over one command byte after each start condition. The sequencer checks that the byte is addressed to this device. It then either accesses a per-channel limit register or starts conversions on an external successive-approximation converter. The converter is reached through a start strobe, a channel index and a ready/result handshake.

Four conversion modes come from the channel code and the read/monitor bit: a single conversion, endless repeats on one channel, one pass over all channels, and autonomous monitoring that cycles over all channels. Every finished conversion is compared against that channel's upper and lower limits. A channel out of range latches a flag, and the active-low alert stays asserted until a clear strobe arrives.

Top module: `adc_cmd_seq`

## Requirements
- R1: Command bits [7:4] must equal the device identifier, which is {dev_addr, 1'b1} when STRAP_ID=1 (the default) and 4'b1001 otherwise. A byte with any other identifier is ignored and leaves any activity in progress unchanged.
- R2: Bit [3] picks the operation: 0 converts, 1 accesses a limit register. With bit [3]=1, bits [2:1] give the channel (0..2) and lim_hi picks the upper (1) or lower (0) limit. Bit [0]=0 writes lim_wdata; bit [0]=1 returns the limit on rd_data with rd_valid one cycle after the command.
- R3: A conversion command raises acq on the next clock edge. acq stays high until a clock edge that samples ack_end high. conv_start pulses in the following cycle and never while acq is high.
- R4: Bits [2:1] in 0..2 with bit [0]=1 give one conversion on that channel. The result appears on rd_data with a one-cycle rd_valid, and the sequencer then idles.
- R5: Bits [2:1] in 0..2 with bit [0]=0 repeat conversions on that channel back-to-back.
- R6: Channel code 3 with bit [0]=1 converts channels 0, 1, 2 once each, in that order, reports each result on rd_data, and then stops.
- R7: Channel code 3 with bit [0]=0 converts channels 0, 1, 2, 0, 1, … without further commands, wrapping after channel 2. No rd_valid is produced in this mode.
- R8: A result above the channel's upper limit or below its lower limit sets that channel's flag and drives alert_n low. A result equal to either limit is in range.
- R9: alert_n stays low once set, through any number of later in-range results, until alert_clr is pulsed.
- R10: After reset, every upper limit is 10'h3FF, every lower limit is 10'h000, alert_n is high, and acq, conv_start and rd_valid are low.
- R11: Any accepted command ends the conversion activity in progress. After a limit-register command, no further conv_start occurs, and a late converter result is neither compared nor reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 3 | Strap pins forming the upper identifier bits |
| cmd_valid | input | 1 | One-cycle strobe: cmd_byte holds a received command |
| cmd_byte | input | 8 | Identifier, operation, channel code, read/monitor bit |
| lim_hi | input | 1 | Limit access selects upper (1) or lower (0) limit |
| lim_wdata | input | 10 | Data for a limit write |
| ack_end | input | 1 | End of the acknowledge period, closing acquisition |
| alert_clr | input | 1 | Clears all latched alert flags |
| adc_ready | input | 1 | Converter result valid strobe |
| adc_result | input | 10 | Converter result |
| acq | output | 1 | Sample-and-hold acquisition window open |
| conv_start | output | 1 | Conversion start pulse |
| conv_ch | output | 2 | Channel being acquired or converted |
| rd_valid | output | 1 | rd_data carries a result or limit value |
| rd_data | output | 10 | Read-back data |
| alert_n | output | 1 | Active-low out-of-limit alert |

## Verification
A table of single conversions covers results strictly inside the limits, exactly on the upper limit, exactly on the lower limit, and one code beyond each limit, on every channel. These cases separate an inclusive comparison from a strict one and show which side of the window is checked. The channel sequences logged from conv_start separate the four modes: a one-shot pass 0,1,2 that stops, a wrapping 0,1,2,0,1, and a fixed repeated channel. Commands with a wrong identifier, and limit commands sent during monitoring, show that ignoring a command differs from aborting the activity in progress. Reading back the limits after reset shows the default window.

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq #(
  parameter int W        = 10,
  parameter int NCH      = 3,
  parameter bit STRAP_ID = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   dev_addr,
  input  logic         cmd_valid,
  input  logic [7:0]   cmd_byte,
  input  logic         lim_hi,
  input  logic [W-1:0] lim_wdata,
  input  logic         ack_end,
  input  logic         alert_clr,
  input  logic         adc_ready,
  input  logic [W-1:0] adc_result,
  output logic         acq,
  output logic         conv_start,
  output logic [1:0]   conv_ch,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         alert_n
);
  localparam logic [1:0] LAST = 2'(NCH - 1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} st_t;
  st_t st;

  logic [W-1:0] hi_q [NCH];
  logic [W-1:0] lo_q [NCH];
  logic [NCH-1:0] flags;
  logic auto_q, rep_q, rdo_q;

  wire [3:0] my_id = STRAP_ID ? {dev_addr, 1'b1} : 4'b1001;
  wire       hit   = cmd_valid && (cmd_byte[7:4] == my_id);
  wire       c_op  = cmd_byte[3];
  wire [1:0] c_ch  = cmd_byte[2:1];
  wire       c_rm  = cmd_byte[0];
  wire       c_ok  = c_ch <= LAST;

  wire       last  = conv_ch == LAST;
  wire [1:0] nxt   = auto_q ? (last ? 2'd0 : conv_ch + 2'd1) : conv_ch;
  wire       more  = rep_q || (auto_q && !last);
  wire       done  = (st == S_CONV) && adc_ready && !hit;
  wire       oor   = (adc_result > hi_q[conv_ch]) || (adc_result < lo_q[conv_ch]);
  wire [NCH-1:0] set_v = (done && oor) ? ({{(NCH-1){1'b0}}, 1'b1} << conv_ch) : '0;

  assign acq     = st == S_ACQ;
  assign alert_n = ~|flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= 2'd0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      auto_q     <= 1'b0;
      rep_q      <= 1'b0;
      rdo_q      <= 1'b0;
      flags      <= '0;
      for (int i = 0; i < NCH; i++) begin
        hi_q[i] <= TOP;
        lo_q[i] <= '0;
      end
    end else begin
      conv_start <= 1'b0;
      rd_valid   <= 1'b0;
      flags      <= (alert_clr ? '0 : flags) | set_v;
      if (hit) begin
        if (!c_op) begin
          st      <= S_ACQ;
          auto_q  <= c_ch == 2'd3;
          conv_ch <= (c_ch == 2'd3) ? 2'd0 : c_ch;
          rep_q   <= !c_rm;
          rdo_q   <= c_rm;
        end else begin
          st <= S_IDLE;
          if (c_ok) begin
            if (c_rm) begin
              rd_valid <= 1'b1;
              rd_data  <= lim_hi ? hi_q[c_ch] : lo_q[c_ch];
            end else if (lim_hi) begin
              hi_q[c_ch] <= lim_wdata;
            end else begin
              lo_q[c_ch] <= lim_wdata;
            end
          end
        end
      end else begin
        case (st)
          S_ACQ: if (ack_end) begin
            st         <= S_CONV;
            conv_start <= 1'b1;
          end
          S_CONV: if (adc_ready) begin
            if (rdo_q) begin
              rd_valid <= 1'b1;
              rd_data  <= adc_result;
            end
            if (more) begin
              conv_ch    <= nxt;
              conv_start <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
  parameter int W        = 10,
  parameter bit STRAP_ID = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   dev_addr,
  input logic         cmd_valid,
  input logic [7:0]   cmd_byte,
  input logic         alert_clr,
  input logic         adc_ready,
  input logic         acq,
  input logic         conv_start,
  input logic [1:0]   conv_ch,
  input logic         alert_n
);
  wire [3:0] exp_id = STRAP_ID ? {dev_addr, 1'b1} : 4'b1001;

  AST_BAD_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:4] != exp_id && !acq) |=> !acq); // R1
  AST_NO_START_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> !conv_start); // R3
  AST_START_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(acq) && !$past(cmd_valid)) |-> conv_start); // R3
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_ch <= 2'd2); // R6
  AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(adc_ready)); // R8
  AST_ALERT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_clr && !adc_ready) |=> alert_n); // R9
endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(.W(W), .STRAP_ID(STRAP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .alert_clr(alert_clr), .adc_ready(adc_ready),
  .acq(acq), .conv_start(conv_start), .conv_ch(conv_ch), .alert_n(alert_n)
);

// File: tb/adc_cmd_seq_tb.sv
module adc_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] GOOD = 4'b1011;
  localparam logic [3:0] BAD  = 4'b1001;
  localparam int NV = 8;
  // {ch[1:0], value[9:0], upper[9:0], lower[9:0], expect_alert}
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 10'd200,  10'd300,  10'd100, 1'b0},
    {2'd1, 10'd300,  10'd300,  10'd100, 1'b0},
    {2'd2, 10'd100,  10'd300,  10'd100, 1'b0},
    {2'd0, 10'd301,  10'd300,  10'd100, 1'b1},
    {2'd1, 10'd99,   10'd300,  10'd100, 1'b1},
    {2'd2, 10'd1023, 10'd1023, 10'd0,   1'b0},
    {2'd0, 10'd0,    10'd1023, 10'd1,   1'b1},
    {2'd2, 10'd512,  10'd511,  10'd0,   1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] dev_addr = 3'b101;
  logic cmd_valid = 0, lim_hi = 0, ack_end = 0, alert_clr = 0, adc_ready = 0;
  logic [7:0] cmd_byte = 0;
  logic [9:0] lim_wdata = 0, adc_result = 0;
  logic acq, conv_start, rd_valid, alert_n;
  logic [1:0] conv_ch;
  logic [9:0] rd_data;

  int checks = 0, errors = 0;
  logic [9:0] ana [3];
  logic [1:0] sc_ch [256];
  logic [9:0] rd_v [256];
  int sc_n = 0, rd_n = 0;

  adc_cmd_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mk(input logic [3:0] id, input logic op,
                                    input logic [1:0] ch, input logic rm);
    return {id, op, ch, rm};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic hs, input logic [9:0] d);
    cmd_valid = 1; cmd_byte = c; lim_hi = hs; lim_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic ack();
    ack_end = 1;
    @(negedge clk);
    ack_end = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
  endtask

  // converter model: result three negedges after the start is seen
  initial begin
    int cnt = 0;
    logic [1:0] chl = 0;
    bit pend = 0;
    forever begin
      @(negedge clk);
      adc_ready = 0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          adc_ready = 1; adc_result = ana[chl]; pend = 0;
        end
      end
      if (conv_start) begin
        pend = 1; cnt = 3; chl = conv_ch;
      end
    end
  end

  // output loggers
  initial forever begin
    @(negedge clk);
    if (conv_start && sc_n < 256) begin sc_ch[sc_n] = conv_ch; sc_n++; end
    if (rd_valid && rd_n < 256) begin rd_v[rd_n] = rd_data; rd_n++; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0, r0;
    ana[0] = 0; ana[1] = 0; ana[2] = 0;
    wait_n(2);
    chk(alert_n === 1 && acq === 0 && conv_start === 0 && rd_valid === 0, "R10 reset outputs", alert_n, 1);
    rst_n = 1;
    wait_n(1);

    send(mk(GOOD, 1, 2'd1, 1), 1, 0);
    chk(rd_valid === 1 && rd_data === 10'h3FF, "R10 upper default", rd_data, 10'h3FF);
    send(mk(GOOD, 1, 2'd0, 1), 0, 0);
    chk(rd_valid === 1 && rd_data === 10'h000, "R10 lower default", rd_data, 0);

    // R8/R4 table of single conversions
    for (int i = 0; i < NV; i++) begin
      logic [1:0] ch;
      logic [9:0] v, h, l;
      logic ea;
      {ch, v, h, l, ea} = VEC[i];
      send(mk(GOOD, 1, ch, 0), 1, h);
      send(mk(GOOD, 1, ch, 0), 0, l);
      alert_clr = 1; wait_n(1); alert_clr = 0;
      ana[ch] = v;
      r0 = rd_n;
      send(mk(GOOD, 0, ch, 1), 0, 0);
      ack();
      wait_n(10);
      chk(rd_n == r0 + 1 && rd_v[r0] === v, "R4 single result", rd_v[r0], v);
      chk(alert_n === !ea, "R8 limit compare", alert_n, !ea);
    end

    wait_n(5);
    chk(alert_n === 0, "R9 alert sticky", alert_n, 0);
    alert_clr = 1; wait_n(1); alert_clr = 0;
    chk(alert_n === 1, "R9 alert cleared", alert_n, 1);

    do_reset();
    ana[0] = 10'd11; ana[1] = 10'd22; ana[2] = 10'd33;

    // R1 wrong identifier ignored
    s0 = sc_n; r0 = rd_n;
    send(mk(BAD, 0, 2'd0, 1), 0, 0);
    chk(acq === 0, "R1 no acquisition", acq, 0);
    ack();
    send(mk(BAD, 1, 2'd0, 1), 1, 0);
    wait_n(10);
    chk(sc_n == s0 && rd_n == r0, "R1 mismatch ignored", sc_n - s0, 0);

    // R3 acquisition window
    send(mk(GOOD, 0, 2'd2, 1), 0, 0);
    chk(acq === 1 && conv_start === 0, "R3 acquire open", acq, 1);
    wait_n(2);
    chk(acq === 1 && conv_start === 0, "R3 held until ack", conv_start, 0);
    ack();
    chk(conv_start === 1 && acq === 0 && conv_ch === 2'd2, "R3 start after ack", conv_start, 1);
    r0 = rd_n;
    wait_n(10);
    chk(rd_n == r0 + 1 && rd_v[r0] === 10'd33, "R4 channel 2 result", rd_v[r0], 33);

    // R6 one pass over all channels
    s0 = sc_n; r0 = rd_n;
    send(mk(GOOD, 0, 2'd3, 1), 0, 0);
    ack();
    wait_n(40);
    chk(sc_n == s0 + 3 && sc_ch[s0] == 0 && sc_ch[s0+1] == 1 && sc_ch[s0+2] == 2,
        "R6 channel order", sc_n - s0, 3);
    chk(rd_n == r0 + 3 && rd_v[r0] === 10'd11 && rd_v[r0+1] === 10'd22 && rd_v[r0+2] === 10'd33,
        "R6 results", rd_v[r0+2], 33);

    // R7 autonomous wrap
    s0 = sc_n; r0 = rd_n;
    send(mk(GOOD, 0, 2'd3, 0), 0, 0);
    ack();
    wait_n(40);
    chk(sc_n >= s0 + 6, "R7 back-to-back", sc_n - s0, 6);
    chk(sc_ch[s0] == 0 && sc_ch[s0+1] == 1 && sc_ch[s0+2] == 2 && sc_ch[s0+3] == 0 && sc_ch[s0+4] == 1,
        "R7 wrap order", sc_ch[s0+3], 0);
    chk(rd_n == r0, "R7 no reads", rd_n - r0, 0);

    // R11 limit write aborts monitoring
    send(mk(GOOD, 1, 2'd1, 0), 1, 10'd20);
    s0 = sc_n;
    wait_n(20);
    chk(sc_n == s0, "R11 monitoring stopped", sc_n - s0, 0);
    chk(alert_n === 1, "R11 late result not compared", alert_n, 1);

    // R5 repeat on one channel, alert from monitoring
    s0 = sc_n;
    send(mk(GOOD, 0, 2'd1, 0), 0, 0);
    ack();
    wait_n(30);
    chk(sc_n >= s0 + 5 && sc_ch[s0] == 1 && sc_ch[s0+2] == 1 && sc_ch[s0+4] == 1,
        "R5 same channel", sc_ch[s0+4], 1);
    chk(alert_n === 0, "R8 monitor alert", alert_n, 0);

    r0 = rd_n;
    send(mk(GOOD, 1, 2'd1, 1), 1, 0);
    wait_n(10);
    chk(rd_n == r0 + 1 && rd_v[r0] === 10'd20, "R2 limit readback", rd_v[r0], 20);
    s0 = sc_n;
    wait_n(10);
    chk(sc_n == s0, "R11 read stops repeat", sc_n - s0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule